// File: doc/BRIEF.md
# Broadcast Single-Slot Message Channel

This block is a hardware message channel between concurrent processes on a chip. Any number of producer ports can post a fixed-width word into one shared storage slot, and any number of consumer ports can pick that word up. A post is never refused or delayed: it is taken at the next clock edge whatever the slot holds. If the slot still holds a word that some consumer has not yet taken, the new word replaces it and the old one is lost.

Each consumer asks for data by raising a request and holding it. If the slot holds a word that this consumer has not yet taken, the consumer is released at once. Otherwise it stays blocked until a new word is posted. Every consumer keeps its own unread bit, so a single posted word can reach every consumer exactly once. A sticky loss flag reports words that were overwritten before being read, or that were dropped because two producers posted in the same cycle. The flag stays set until it is cleared explicitly.

Each consumer runs a small state machine with three states. `RX_IDLE` means no request is pending. `RX_WAIT` means a request is blocked on an empty or already-read slot. `RX_ACK` is the one-cycle release. Its transitions are:

- IDLE→ACK: a request arrives while unread.
- IDLE→WAIT: a request arrives while nothing is unread.
- WAIT→ACK: a word becomes unread.
- WAIT→IDLE: the request is withdrawn.
- ACK→IDLE: always.

Top module: `bcast_slot_chan`

## Requirements
- R1: After reset every `rcv_ack` bit is low, `ovr_flag` is low, and no consumer holds an unread word, so a request made before any post blocks.
- R2: A post (`snd_valid` bit high) is accepted at the next clock edge whatever the slot state. The stored word then counts as unread for every consumer.
- R3: A request held while the consumer has no unread word gives no acknowledge. When a word is posted at clock edge k, the acknowledge is high in the cycle after edge k+1.
- R4: A request raised while the consumer has an unread word gives an acknowledge in the cycle after the next clock edge.
- R5: The acknowledge is high for exactly one cycle. While it is high, the consumer's slice of `rcv_data` (bits i*WIDTH up to i*WIDTH+WIDTH-1) carries the delivered word.
- R6: Several consumers can receive the same word. A take by one consumer does not clear the unread state of another.
- R7: A post that arrives while a word is still unread replaces it. A later take returns the newest word.
- R8: `ovr_flag` becomes 1 at the edge after a post that overwrites a word still unread by some consumer not taking it in that cycle, or a post with two or more `snd_valid` bits high. It then holds until `ovr_clr` is high at an edge with no new loss. A loss wins over a clear at the same edge.
- R9: When several producers post in the same cycle, the producer with the lowest index is stored.
- R10: Once a consumer has taken a word, a further request from it blocks until another post.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_valid | input | N_SEND | Per-producer post strobe |
| snd_data | input | N_SEND*WIDTH | Producer words, producer i in slice i |
| ovr_clr | input | 1 | Clears the loss flag |
| rcv_req | input | N_RECV | Per-consumer request, held until acknowledge |
| rcv_ack | output | N_RECV | Per-consumer one-cycle release |
| rcv_data | output | N_RECV*WIDTH | Delivered word, consumer i in slice i |
| ovr_flag | output | 1 | Sticky loss indicator |

## Verification
A wrong unread bit shows up on the next request from that consumer. A stuck-set bit releases it one cycle after the request, with a word it has already taken. A stuck-clear bit leaves it blocked. A bad slot or capture register shows as the wrong word on the acknowledge cycle. A wrong priority choice shows on the first take after a collision. A flag error is visible at `ovr_flag` one edge after the offending post or clear. The bench therefore places a request or flag sample right after every post pattern, so that each fault surfaces within two cycles.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_WAIT = 2'd1,
        RX_ACK  = 2'd2
    } rx_state_e;
endpackage

// File: rtl/bsc_send_pick.sv
module bsc_send_pick #(
    parameter int WIDTH  = 16,
    parameter int N_SEND = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SEND-1:0]       valid,
    input  logic [N_SEND*WIDTH-1:0] data,
    output logic                    wr,
    output logic [WIDTH-1:0]        word,
    output logic                    collide
);
    localparam int CNT_W = $clog2(N_SEND + 1);

    logic [N_SEND-1:0] grant;
    logic [CNT_W-1:0]  cnt;
    logic              hit;

    // lowest index wins; count every poster to spot collisions
    always_comb begin
        grant = '0;
        word  = '0;
        cnt   = '0;
        hit   = 1'b0;
        for (int i = 0; i < N_SEND; i++) begin
            if (valid[i]) begin
                cnt = cnt + CNT_W'(1);
                if (!hit) begin
                    grant[i] = 1'b1;
                    word     = data[i*WIDTH +: WIDTH];
                    hit      = 1'b1;
                end
            end
        end
    end

    assign wr      = hit;
    assign collide = (cnt > CNT_W'(1));

    // R9
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R9
    grant_when_posted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|valid) |-> ($countones(grant) == 1));
endmodule

// File: rtl/bsc_slot_store.sv
module bsc_slot_store #(
    parameter int WIDTH  = 16,
    parameter int N_RECV = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WIDTH-1:0]  wr_word,
    input  logic              collide,
    input  logic [N_RECV-1:0] consume,
    input  logic              clr,
    output logic [WIDTH-1:0]  slot_word,
    output logic [N_RECV-1:0] unread,
    output logic              ovr
);
    logic [WIDTH-1:0]  slot_q;
    logic [N_RECV-1:0] unread_q, unread_d;
    logic              ovr_q, ovr_d, lost;

    assign lost = wr && (collide || (|(unread_q & ~consume)));

    always_comb begin
        for (int i = 0; i < N_RECV; i++) begin
            if (wr)
                unread_d[i] = 1'b1;
            else if (consume[i])
                unread_d[i] = 1'b0;
            else
                unread_d[i] = unread_q[i];
        end
        if (lost)
            ovr_d = 1'b1;
        else if (clr)
            ovr_d = 1'b0;
        else
            ovr_d = ovr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q   <= '0;
            unread_q <= '0;
            ovr_q    <= 1'b0;
        end else begin
            if (wr)
                slot_q <= wr_word;
            unread_q <= unread_d;
            ovr_q    <= ovr_d;
        end
    end

    assign slot_word = slot_q;
    assign unread    = unread_q;
    assign ovr       = ovr_q;

    // R2
    post_marks_unread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (&unread_q));
    // R2
    post_stores_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (slot_q == $past(wr_word)));
    // R8
    loss_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> ovr_q);
    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !clr) |=> ovr_q);
endmodule

// File: rtl/bsc_rx_fsm.sv
module bsc_rx_fsm
    import bsc_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             unread,
    input  logic [WIDTH-1:0] slot_word,
    output logic             consume,
    output logic             ack,
    output logic [WIDTH-1:0] data
);
    rx_state_e        state_q, state_d;
    logic [WIDTH-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (req) state_d = unread ? RX_ACK : RX_WAIT;
            RX_WAIT: begin
                if (!req)        state_d = RX_IDLE;
                else if (unread) state_d = RX_ACK;
            end
            RX_ACK:  state_d = RX_IDLE;
            default: state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (consume)
                data_q <= slot_word;
        end
    end

    always_comb begin
        consume = (state_q != RX_ACK) && (state_d == RX_ACK);
        ack     = (state_q == RX_ACK);
        data    = data_q;
    end

    // R5
    ack_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    // R3
    take_then_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> ack);
    // R10
    no_take_without_unread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> (unread && req));
endmodule

// File: rtl/bcast_slot_chan.sv
module bcast_slot_chan #(
    parameter int WIDTH  = 16,
    parameter int N_SEND = 3,
    parameter int N_RECV = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SEND-1:0]       snd_valid,
    input  logic [N_SEND*WIDTH-1:0] snd_data,
    input  logic                    ovr_clr,
    input  logic [N_RECV-1:0]       rcv_req,
    output logic [N_RECV-1:0]       rcv_ack,
    output logic [N_RECV*WIDTH-1:0] rcv_data,
    output logic                    ovr_flag
);
    logic              wr, collide;
    logic [WIDTH-1:0]  wr_word, slot_word;
    logic [N_RECV-1:0] unread, consume;

    bsc_send_pick #(.WIDTH(WIDTH), .N_SEND(N_SEND)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (snd_valid),
        .data    (snd_data),
        .wr      (wr),
        .word    (wr_word),
        .collide (collide)
    );

    bsc_slot_store #(.WIDTH(WIDTH), .N_RECV(N_RECV)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr),
        .wr_word   (wr_word),
        .collide   (collide),
        .consume   (consume),
        .clr       (ovr_clr),
        .slot_word (slot_word),
        .unread    (unread),
        .ovr       (ovr_flag)
    );

    for (genvar g = 0; g < N_RECV; g++) begin : g_rx
        bsc_rx_fsm #(.WIDTH(WIDTH)) u_rx (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (rcv_req[g]),
            .unread    (unread[g]),
            .slot_word (slot_word),
            .consume   (consume[g]),
            .ack       (rcv_ack[g]),
            .data      (rcv_data[g*WIDTH +: WIDTH])
        );
    end
endmodule

// File: tb/bcast_slot_chan_bench.sv
module bcast_slot_chan_bench;
    localparam int W  = 16;
    localparam int NS = 3;
    localparam int NR = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS-1:0]   snd_valid = '0;
    logic [NS*W-1:0] snd_data = '0;
    logic            ovr_clr = 1'b0;
    logic [NR-1:0]   rcv_req = '0;
    logic [NR-1:0]   rcv_ack;
    logic [NR*W-1:0] rcv_data;
    logic            ovr_flag;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] exp_q [NR][$];
    logic [NR-1:0] prev_ack = '0;

    always #5 clk = ~clk;

    bcast_slot_chan #(.WIDTH(W), .N_SEND(NS), .N_RECV(NR)) u_bcast_slot_chan (
        .clk(clk), .rst_n(rst_n), .snd_valid(snd_valid), .snd_data(snd_data),
        .ovr_clr(ovr_clr), .rcv_req(rcv_req), .rcv_ack(rcv_ack),
        .rcv_data(rcv_data), .ovr_flag(ovr_flag)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected words as acknowledges appear
    always @(negedge clk) begin
        for (int i = 0; i < NR; i++) begin
            if (rcv_ack[i]) begin
                // R5 one-cycle pulse
                chk(!prev_ack[i], "R5 ack pulse width", 1, 0);
                if (exp_q[i].size() == 0)
                    chk(1'b0, "R6 unexpected delivery", int'(rcv_data[i*W +: W]), 0);
                else begin
                    logic [W-1:0] e;
                    e = exp_q[i].pop_front();
                    chk(rcv_data[i*W +: W] == e, "R5 delivered word",
                        int'(rcv_data[i*W +: W]), int'(e));
                end
            end
        end
        prev_ack <= rcv_ack;
    end

    task automatic post(input logic [NS-1:0] v, input logic [NS*W-1:0] d);
        snd_valid = v;
        snd_data  = d;
        @(negedge clk);
        snd_valid = '0;
    endtask

    task automatic expect_word(input int i, input logic [W-1:0] w);
        exp_q[i].push_back(w);
    endtask

    // request and count negedges until the acknowledge is seen
    task automatic take(input int i, input int lat, input string tag);
        int n = 0;
        rcv_req[i] = 1'b1;
        while (n < 10) begin
            @(negedge clk);
            n++;
            if (rcv_ack[i]) break;
        end
        rcv_req[i] = 1'b0;
        chk(n == lat, tag, n, lat);
    endtask

    task automatic idle_blocked(input int i, input int cyc, input string tag);
        bit seen = 1'b0;
        rcv_req[i] = 1'b1;
        for (int k = 0; k < cyc; k++) begin
            @(negedge clk);
            if (rcv_ack[i]) seen = 1'b1;
        end
        chk(!seen, tag, int'(seen), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rcv_ack == '0, "R1 ack after reset", int'(rcv_ack), 0);
        chk(ovr_flag == 1'b0, "R1 flag after reset", int'(ovr_flag), 0);
        idle_blocked(2, 3, "R1 request before any post blocks");
        rcv_req[2] = 1'b0;
        @(negedge clk);

        // R2 R4 R6: one word reaches every consumer
        post(3'b010, {16'h0, 16'hA5A5, 16'h0});
        for (int i = 0; i < NR; i++) expect_word(i, 16'hA5A5);
        rcv_req = '1;
        @(negedge clk);
        chk(rcv_ack == '1, "R4 R6 broadcast ack latency", int'(rcv_ack), 7);
        rcv_req = '0;
        @(negedge clk);
        chk(ovr_flag == 1'b0, "R8 no loss when all read", int'(ovr_flag), 0);

        // R10 then R3: blocked after take, released by a new post
        idle_blocked(0, 4, "R10 second request blocks");
        expect_word(0, 16'h1234);
        snd_valid = 3'b001; snd_data = {32'h0, 16'h1234};
        @(negedge clk);
        snd_valid = '0;
        chk(rcv_ack[0] == 1'b0, "R3 not yet released", int'(rcv_ack[0]), 0);
        @(negedge clk);
        chk(rcv_ack[0] == 1'b1, "R3 released after post", int'(rcv_ack[0]), 1);
        rcv_req[0] = 1'b0;
        @(negedge clk);
        // R6 consumer 0 take left 1 and 2 unread
        expect_word(1, 16'h1234);
        take(1, 1, "R6 independent unread bit");
        expect_word(2, 16'h1234);
        take(2, 1, "R6 independent unread bit c2");

        // R7 R8 overwrite
        post(3'b100, {16'hC0C0, 32'h0});
        post(3'b100, {16'hD0D0, 32'h0});
        chk(ovr_flag == 1'b1, "R8 overwrite sets flag", int'(ovr_flag), 1);
        for (int i = 0; i < NR; i++) begin
            expect_word(i, 16'hD0D0);
            take(i, 1, "R7 newest word delivered");
        end
        chk(ovr_flag == 1'b1, "R8 flag sticky", int'(ovr_flag), 1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        chk(ovr_flag == 1'b0, "R8 clear", int'(ovr_flag), 0);

        // R9 collision
        post(3'b110, {16'h7777, 16'h5555, 16'h0});
        chk(ovr_flag == 1'b1, "R8 collision sets flag", int'(ovr_flag), 1);
        expect_word(0, 16'h5555);
        take(0, 1, "R9 lowest index wins");
        ovr_clr = 1'b1;
        @(negedge clk);
        chk(ovr_flag == 1'b0, "R8 clear after collision", int'(ovr_flag), 0);

        // R8 loss beats clear (consumers 1,2 still unread)
        snd_valid = 3'b001; snd_data = {32'h0, 16'h9999};
        @(negedge clk);
        snd_valid = '0;
        ovr_clr = 1'b0;
        chk(ovr_flag == 1'b1, "R8 loss wins over clear", int'(ovr_flag), 1);
        for (int i = 0; i < NR; i++) begin
            expect_word(i, 16'h9999);
            take(i, 1, "R7 word after contested clear");
        end
        @(negedge clk);
        for (int i = 0; i < NR; i++)
            chk(exp_q[i].size() == 0, "R6 all expected words delivered",
                exp_q[i].size(), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule